// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A parameterised general-purpose I/O port, 12 pins wide by default, driven through a small register-mapped bus with a write strobe, a word address, write data and combinational read data. Each pin can be an input or an output. Writes to the output register are gated bit by bit by an access mask, and a separate write-one register pulls chosen output bits low.

Every pin has its own interrupt detector. Each pin selects edge or level sensing, single-edge or both-edge triggering, and rising/high or falling/low polarity. Edge detections are held until software clears them with a write of one. Raw status and enable-masked status can be read back. All masked bits are ORed onto a single interrupt line. Pin inputs pass through a two-flop synchroniser before they are read or sensed.

Top module: `gpio_port`

## Requirements
- R1: Word addresses are: 0x0 data, 0x1 direction, 0x2 access mask, 0x3 output clear, 0x4 sense, 0x5 both-edges, 0x6 polarity, 0x7 interrupt enable, 0x8 raw status (read only), 0x9 masked status (read only), 0xA interrupt clear. Unmapped addresses read zero.
- R2: A direction bit of 1 makes the pin an output (`pin_oe_o` high) and 0 makes it an input. A data read returns the output register bit for output pins and the synchronised pin value for input pins.
- R3: A data write changes only the output register bits whose access mask bit is 0. Bits whose mask bit is 1 keep their value.
- R4: A write to the output clear address drives low each output register bit written as 1 whose mask bit is 0. All other bits are unchanged.
- R5: With sense 0 and both-edges 0, polarity 1 latches raw status on a rising edge and polarity 0 latches it on a falling edge. The opposite edge does not set it. The latched status stays set after the pin returns to its earlier level, and it is visible within four clock edges of the pin change.
- R6: With sense 0 and both-edges 1, both rising and falling transitions latch raw status, whatever the polarity bit is.
- R7: With sense 1, raw status follows the synchronised pin level: it is set while the pin is high if polarity is 1, and while the pin is low if polarity is 0. An interrupt clear write does not change it.
- R8: Raw status shows detections whatever the enable bit is. Masked status equals raw status ANDed with the enable register.
- R9: `irq_o` is high exactly when any masked status bit is high.
- R10: An interrupt clear write resets the latched edge status of each bit written as 1. If a new edge on that pin arrives in the same cycle, the edge wins and the status stays set.
- R11: After reset all registers, `pin_o`, `pin_oe_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data for `bus_addr_i` (combinational) |
| pin_i | input | WIDTH | Asynchronous pin inputs |
| pin_o | output | WIDTH | Output register value |
| pin_oe_o | output | WIDTH | Per-pin output enable (direction) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can act on the same latch in one cycle: an interrupt clear write to a both-edge pin and a fresh transition of that pin. The bench toggles the pin and then times the clear write so that it reaches the register on the exact edge where the synchronised transition is detected. After that write it expects raw status to still be set. A later clear write with no transition must then drop the status.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_DATA  = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_DIR   = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_OCLR  = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_SENSE = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_BOTH  = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_POL   = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_EN    = 4'h7;
  localparam logic [ADDR_W-1:0] ADR_RAW   = 4'h8;
  localparam logic [ADDR_W-1:0] ADR_MSK   = 4'h9;
  localparam logic [ADDR_W-1:0] ADR_ICLR  = 4'hA;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_bit.sv
module gpio_irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic sense_i,   // 1: level
  input  logic both_i,
  input  logic pol_i,     // 1: rising / high
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q;
  logic lat_q;
  logic rise, fall, edge_hit, edge_ev, level_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_i;
  end

  assign rise      = sync_i & ~prev_q;
  assign fall      = ~sync_i & prev_q;
  assign edge_hit  = both_i ? (rise | fall) : (pol_i ? rise : fall);
  assign edge_ev   = edge_hit & ~sense_i;
  assign level_hit = pol_i ? sync_i : ~sync_i;

  // new edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= 1'b0;
    else         lat_q <= (lat_q & ~clr_i) | edge_ev;
  end

  assign raw_o = sense_i ? level_hit : lat_q;

  // R10
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_ev |=> lat_q);

  // R10
  clr_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_ev) |=> !lat_q);

  // R5
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !clr_i) |=> lat_q);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  sync_i,
  input  logic [WIDTH-1:0]  raw_i,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  sense_o,
  output logic [WIDTH-1:0]  both_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  iclr_o,
  output logic [WIDTH-1:0]  masked_o
);
  logic [WIDTH-1:0] out_q, dir_q, mask_q, sense_q, both_q, pol_q, en_q;
  logic [WIDTH-1:0] open_bits;

  assign open_bits = wdata_i & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADR_DATA:  out_q   <= (out_q & mask_q) | open_bits;
        ADR_OCLR:  out_q   <= out_q & ~open_bits;
        ADR_DIR:   dir_q   <= wdata_i;
        ADR_MASK:  mask_q  <= wdata_i;
        ADR_SENSE: sense_q <= wdata_i;
        ADR_BOTH:  both_q  <= wdata_i;
        ADR_POL:   pol_q   <= wdata_i;
        ADR_EN:    en_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  assign iclr_o   = (we_i && addr_i == ADR_ICLR) ? wdata_i : '0;
  assign masked_o = raw_i & en_q;

  always_comb begin
    case (addr_i)
      ADR_DATA:  rdata_o = (dir_q & out_q) | (~dir_q & sync_i);
      ADR_DIR:   rdata_o = dir_q;
      ADR_MASK:  rdata_o = mask_q;
      ADR_SENSE: rdata_o = sense_q;
      ADR_BOTH:  rdata_o = both_q;
      ADR_POL:   rdata_o = pol_q;
      ADR_EN:    rdata_o = en_q;
      ADR_RAW:   rdata_o = raw_i;
      ADR_MSK:   rdata_o = masked_o;
      default:   rdata_o = '0;
    endcase
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;

  // R3
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_DATA) |=>
      ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q))));

  // R4
  clr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_OCLR) |=>
      ((out_q & $past(wdata_i & ~mask_q)) == '0));

  // R4
  clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_OCLR) |=>
      ((out_q & ~$past(wdata_i & ~mask_q)) == ($past(out_q) & ~$past(wdata_i & ~mask_q))));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] sync, raw, masked, sense, both, pol, iclr;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .sync_i  (sync),
    .raw_i   (raw),
    .out_o   (pin_o),
    .dir_o   (pin_oe_o),
    .sense_o (sense),
    .both_o  (both),
    .pol_o   (pol),
    .iclr_o  (iclr),
    .masked_o(masked)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_irq
    gpio_irq_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync[g]),
      .sense_i(sense[g]),
      .both_i (both[g]),
      .pol_i  (pol[g]),
      .clr_i  (iclr[g]),
      .raw_o  (raw[g])
    );
  end

  assign irq_o = |masked;

  // R8
  masked_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked & ~raw) == '0);

  // R11
  reset_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_o == '0 && pin_oe_o == '0));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [W-1:0]  pin = '0;
  logic [W-1:0]  pout, poe;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin),
    .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  typedef struct packed {
    logic [W-1:0] dir, mask, wdat, pins, exp_rd, exp_out;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{12'hFFF, 12'h000, 12'hA5A, 12'h000, 12'hA5A, 12'hA5A},
    '{12'h000, 12'h000, 12'hFFF, 12'h3C3, 12'h3C3, 12'hFFF},
    '{12'h0FF, 12'h0F0, 12'hFFF, 12'hF00, 12'hF0F, 12'hF0F},
    '{12'hFF0, 12'hF00, 12'h5A5, 12'h00F, 12'h0AF, 12'h0A5}
  };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 pin_o", pout, '0);
    chk("R11 pin_oe_o", poe, '0);
    chk("R11 irq_o", {11'd0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h1, v); chk("R11 dir reg", v, '0);
    rd(4'h7, v); chk("R11 enable reg", v, '0);
    rd(4'hF, v); chk("R1 unmapped read", v, '0);

    // R2 R3 table
    for (int i = 0; i < 4; i++) begin
      wr(4'h2, 12'h000);
      wr(4'h0, 12'h000);
      wr(4'h1, VECS[i].dir);
      wr(4'h2, VECS[i].mask);
      wr(4'h0, VECS[i].wdat);
      pin = VECS[i].pins;
      settle();
      rd(4'h0, v);
      chk("R2 data read", v, VECS[i].exp_rd);
      chk("R3 output reg", pout, VECS[i].exp_out);
      chk("R2 oe", poe, VECS[i].dir);
    end

    // R4 output clear, mask gated
    wr(4'h2, 12'h000);
    wr(4'h1, 12'hFFF);
    wr(4'h0, 12'hFFF);
    wr(4'h2, 12'h00F);
    wr(4'h3, 12'h0FF);
    chk("R4 clear gated", pout, 12'hF0F);
    wr(4'h2, 12'h000);
    wr(4'h3, 12'h800);
    chk("R4 clear msb", pout, 12'h70F);

    // interrupt setup
    pin = '0;
    wr(4'h1, 12'h000);
    settle();
    wr(4'hA, 12'hFFF);
    rd(4'h8, v); chk("R10 clear all", v, '0);
    wr(4'h6, 12'h029);   // bit0,3,5 rising/high
    wr(4'h5, 12'h044);   // bit2,6 both
    wr(4'h4, 12'h018);   // bit3,4 level
    wr(4'h7, 12'h00F);
    @(negedge clk);
    rd(4'h8, v); chk("R7 level-low pin4", v & 12'h010, 12'h010);
    chk("R9 irq idle", {11'd0, irq}, 12'h000);

    // R5 rising on pin0
    pin[0] = 1'b1; settle();
    rd(4'h8, v); chk("R5 rising latched", v & 12'h001, 12'h001);
    chk("R9 irq on", {11'd0, irq}, 12'h001);
    pin[0] = 1'b0; settle();
    rd(4'h8, v); chk("R5 latch held", v & 12'h001, 12'h001);
    wr(4'hA, 12'h001);
    rd(4'h8, v); chk("R10 clear pin0", v & 12'h001, 12'h000);
    chk("R9 irq off", {11'd0, irq}, 12'h000);

    // R5 falling on pin1
    pin[1] = 1'b1; settle();
    rd(4'h8, v); chk("R5 no rise on falling pin", v & 12'h002, 12'h000);
    pin[1] = 1'b0; settle();
    rd(4'h8, v); chk("R5 falling latched", v & 12'h002, 12'h002);
    wr(4'hA, 12'h002);

    // R6 both edges pin2, polarity 0
    pin[2] = 1'b1; settle();
    rd(4'h8, v); chk("R6 both rise", v & 12'h004, 12'h004);
    wr(4'hA, 12'h004);
    rd(4'h8, v); chk("R10 clear pin2", v & 12'h004, 12'h000);
    pin[2] = 1'b0; settle();
    rd(4'h8, v); chk("R6 both fall", v & 12'h004, 12'h004);
    wr(4'hA, 12'h004);

    // R7 level-high pin3
    rd(4'h8, v); chk("R7 level low idle", v & 12'h008, 12'h000);
    pin[3] = 1'b1; settle();
    rd(4'h8, v); chk("R7 level high", v & 12'h008, 12'h008);
    wr(4'hA, 12'h008);
    rd(4'h8, v); chk("R7 clear ignored", v & 12'h008, 12'h008);
    chk("R9 irq level", {11'd0, irq}, 12'h001);
    pin[3] = 1'b0; settle();
    rd(4'h8, v); chk("R7 level follows", v & 12'h008, 12'h000);

    // R8 disabled pin5
    pin[5] = 1'b1; settle();
    rd(4'h8, v); chk("R8 raw ignores enable", v & 12'h020, 12'h020);
    rd(4'h9, v); chk("R8 masked", v, 12'h000);
    chk("R9 irq masked off", {11'd0, irq}, 12'h000);
    wr(4'h7, 12'h02F);
    rd(4'h9, v); chk("R8 masked enabled", v, 12'h020);
    chk("R9 irq enabled", {11'd0, irq}, 12'h001);
    wr(4'hA, 12'h020);
    wr(4'h7, 12'h00F);

    // R10 clear and edge in same cycle on pin6 (both edges)
    pin[6] = 1'b1; settle();
    rd(4'h8, v); chk("R6 pin6 rise", v & 12'h040, 12'h040);
    @(negedge clk);
    pin[6] = 1'b0;
    @(negedge clk);
    wr(4'hA, 12'h040);
    rd(4'h8, v); chk("R10 edge wins", v & 12'h040, 12'h040);
    settle();
    wr(4'hA, 12'h040);
    rd(4'h8, v); chk("R10 clear alone", v & 12'h040, 12'h000);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule